// File: doc/BRIEF.md
# Two-Phase Stepper Phase Sequencer

This block walks an eight-position sequence that decides, for each of the two bridges of a bipolar stepper driver, whether the bridge is enabled and which way current flows through its winding. It is clocked by a system clock. The step request, rotation direction, half/full select and an active-low home request come in asynchronously. Each is passed through a two-flop synchroniser. Each rising edge of the synchronised step request moves the sequence by one position in half-step mode or by two positions in full-step mode. The direction and the mode are sampled in the same cycle as that edge.

Positions are numbered 1 to 8 and are reported as `stepState` = position minus 1. Odd positions drive both windings. Even positions drive one winding and switch the other bridge off. Full-step mode keeps the parity of the current position. If full step is selected while the sequencer sits on an odd position, it runs two-phase-on drive. If it is selected on an even position, it runs one-phase-on (wave) drive. The home request, or the system reset, returns the sequencer to position 1.

The four bridge outputs are registered, so they change on the same clock edge as `stepState`. They feed the gate logic of bridge A and bridge B directly.

Top module: `stepper_phase_seq`

## Requirements
- R1: After `rst_n` is released, `stepState` is 0 (position 1) and `enA`, `phaseA`, `enB`, `phaseB` are all 1.
- R2: While the synchronised `homeN` is low, `stepState` is forced to 0 and step edges have no effect.
- R3: With `halfSel`=1 and `dirIn`=1, each step edge increments `stepState` by 1, and 7 wraps to 0.
- R4: With `halfSel`=1 and `dirIn`=0, each step edge decrements `stepState` by 1, and 0 wraps to 7.
- R5: With `halfSel`=0, each step edge adds 2 (`dirIn`=1) or subtracts 2 (`dirIn`=0) modulo 8, so the parity of `stepState` never changes.
- R6: Full step from an odd position visits positions 1,3,5,7 (`stepState` 0,2,4,6) forward, and in every one of them both `enA` and `enB` are 1.
- R7: Full step from an even position visits positions 2,4,6,8 (`stepState` 1,3,5,7), and in every one of them exactly one of `enA` and `enB` is 1.
- R8: The outputs follow `stepState` as {enA,phaseA,enB,phaseB}: 0→1111, 1→0011, 2→1011, 3→1000, 4→1010, 5→0010, 6→1110, 7→1100. A disabled bridge has phase 0.
- R9: Only rising edges of `stepIn` advance the sequence. A step input held high or low, a falling edge, or a change of `dirIn` or `halfSel` alone leaves `stepState` unchanged.
- R10: If `stepIn` rises between two clock edges, `stepState` is unchanged after the first and second clock edges that follow and takes its new value at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| stepIn | input | 1 | Asynchronous step request; rising edges advance the sequence |
| dirIn | input | 1 | Asynchronous direction: 1 forward, 0 backward |
| halfSel | input | 1 | Asynchronous mode select: 1 half step, 0 full step |
| homeN | input | 1 | Asynchronous active-low request to return to position 1 |
| stepState | output | 3 | Current position minus 1 |
| enA | output | 1 | Bridge A enable |
| phaseA | output | 1 | Bridge A current sign (1 positive) |
| enB | output | 1 | Bridge B enable |
| phaseB | output | 1 | Bridge B current sign (1 positive) |

## Verification
The bench goes after the wrap points 7→0 and 0→7 in both step sizes. A design that got these wrong would leave the eight-position ring or stall at its end. It switches from half to full step on an odd and on an even position. A design that realigned the parity there would turn wave drive into two-phase drive, or the reverse.

The bench holds the step input high, drops it, and toggles direction and mode with no step. A level-sensitive design, or one that advanced on the falling edge, would move without a rising edge. It counts the clock edges between a step edge and the state change, which catches a missing or extra synchroniser stage. It also pulses the step input while the home request is held low, which exposes a priority that lets the step win.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;

  localparam int unsigned SEQ_POSITIONS = 8;
  localparam int unsigned SEQ_W = $clog2(SEQ_POSITIONS);

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic goHome;
    logic advance;
    logic reverse;
    logic doubleStep;
  } seqCmd_t;

  // bridge drive word
  typedef struct packed {
    logic enA;
    logic phaseA;
    logic enB;
    logic phaseB;
  } bridgeDrive_t;

  // quadrature table: even index -> both windings, odd index -> one winding
  function automatic bridgeDrive_t decodeState(input logic [SEQ_W-1:0] pos);
    bridgeDrive_t d;
    case (pos)
      3'd0:    d = '{enA: 1'b1, phaseA: 1'b1, enB: 1'b1, phaseB: 1'b1};
      3'd1:    d = '{enA: 1'b0, phaseA: 1'b0, enB: 1'b1, phaseB: 1'b1};
      3'd2:    d = '{enA: 1'b1, phaseA: 1'b0, enB: 1'b1, phaseB: 1'b1};
      3'd3:    d = '{enA: 1'b1, phaseA: 1'b0, enB: 1'b0, phaseB: 1'b0};
      3'd4:    d = '{enA: 1'b1, phaseA: 1'b0, enB: 1'b1, phaseB: 1'b0};
      3'd5:    d = '{enA: 1'b0, phaseA: 1'b0, enB: 1'b1, phaseB: 1'b0};
      3'd6:    d = '{enA: 1'b1, phaseA: 1'b1, enB: 1'b1, phaseB: 1'b0};
      default: d = '{enA: 1'b1, phaseA: 1'b1, enB: 1'b0, phaseB: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/seq_input_sync.sv
module seq_input_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[g]}};
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[g]};
      end
    end

    assign syncOut[g] = chain[LAST];
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import stepper_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stepSync,
  input  logic    dirSync,
  input  logic    halfSync,
  input  logic    homeSyncN,
  output seqCmd_t cmd
);

  logic stepPrev;
  logic stepRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepPrev <= 1'b0;
    end else begin
      stepPrev <= stepSync;
    end
  end

  assign stepRise = stepSync & ~stepPrev;

  // home has priority; direction and mode taken in the edge cycle
  always_comb begin
    cmd.goHome     = ~homeSyncN;
    cmd.advance    = stepRise & homeSyncN;
    cmd.reverse    = ~dirSync;
    cmd.doubleStep = ~halfSync;
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import stepper_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seqCmd_t          cmd,
  output logic [SEQ_W-1:0] stepState,
  output bridgeDrive_t     drive
);

  logic [SEQ_W-1:0] stride;
  logic [SEQ_W-1:0] moved;
  logic [SEQ_W-1:0] nextState;

  assign stride = cmd.doubleStep ? SEQ_W'(2) : SEQ_W'(1);
  assign moved  = cmd.reverse ? (stepState - stride) : (stepState + stride);

  always_comb begin
    if (cmd.goHome) begin
      nextState = '0;
    end else if (cmd.advance) begin
      nextState = moved;
    end else begin
      nextState = stepState;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepState <= '0;
      drive     <= decodeState('0);
    end else begin
      stepState <= nextState;
      drive     <= decodeState(nextState);
    end
  end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepIn,
  input  logic             dirIn,
  input  logic             halfSel,
  input  logic             homeN,
  output logic [SEQ_W-1:0] stepState,
  output logic             enA,
  output logic             phaseA,
  output logic             enB,
  output logic             phaseB
);

  localparam int unsigned IN_W = 4;

  logic [IN_W-1:0] syncVec;
  seqCmd_t         cmd;
  bridgeDrive_t    drive;

  seq_input_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1000)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn({homeN, halfSel, dirIn, stepIn}),
    .syncOut(syncVec)
  );

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stepSync (syncVec[0]),
    .dirSync  (syncVec[1]),
    .halfSync (syncVec[2]),
    .homeSyncN(syncVec[3]),
    .cmd      (cmd)
  );

  seq_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .stepState(stepState),
    .drive    (drive)
  );

  assign enA    = drive.enA;
  assign phaseA = drive.phaseA;
  assign enB    = drive.enB;
  assign phaseB = drive.phaseB;

endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk
  import stepper_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input seqCmd_t          cmd,
  input logic [SEQ_W-1:0] stepState,
  input logic             enA,
  input logic             enB
);

  AST_HOME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.goHome |=> stepState == '0); // R2

  AST_HALF_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.advance && !cmd.goHome && !cmd.doubleStep && !cmd.reverse)
      |=> stepState == SEQ_W'($past(stepState) + SEQ_W'(1))); // R3

  AST_HALF_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.advance && !cmd.goHome && !cmd.doubleStep && cmd.reverse)
      |=> stepState == SEQ_W'($past(stepState) - SEQ_W'(1))); // R4

  AST_FULL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.advance && !cmd.goHome && cmd.doubleStep)
      |=> stepState[0] == $past(stepState[0])); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.advance && !cmd.goHome) |=> $stable(stepState)); // R9

  AST_TWO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !stepState[0] |-> (enA && enB)); // R6

  AST_ONE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    stepState[0] |-> $countones({enA, enB}) == 1); // R7

endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .stepState(stepState),
  .enA      (enA),
  .enB      (enB)
);

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stepIn = 1'b0;
  logic       dirIn = 1'b1;
  logic       halfSel = 1'b1;
  logic       homeN = 1'b1;
  logic [2:0] stepState;
  logic       enA, phaseA, enB, phaseB;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  benchDone = 1'b0;
  logic [2:0] expState = 3'd0;

  always #5 clk = ~clk;

  stepper_phase_seq u_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
    .halfSel(halfSel), .homeN(homeN), .stepState(stepState),
    .enA(enA), .phaseA(phaseA), .enB(enB), .phaseB(phaseB)
  );

  // drive word per R8, as {enA,phaseA,enB,phaseB}
  function automatic logic [3:0] expDrive(input logic [2:0] s);
    case (s)
      3'd0: return 4'b1111;
      3'd1: return 4'b0011;
      3'd2: return 4'b1011;
      3'd3: return 4'b1000;
      3'd4: return 4'b1010;
      3'd5: return 4'b0010;
      3'd6: return 4'b1110;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic logic [2:0] expNext(input logic [2:0] s, input logic fwd,
                                         input logic half, input logic home);
    logic [2:0] d;
    if (!home) return 3'd0;
    d = half ? 3'd1 : 3'd2;
    return fwd ? 3'(s + d) : 3'(s - d);
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, {stepState, enA, phaseA, enB, phaseB}, {expState, expDrive(expState)});
  endtask

  task automatic setMode(input logic dir, input logic half);
    @(negedge clk);
    dirIn = dir;
    halfSel = half;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    stepIn = 1'b1;
    repeat (4) @(negedge clk);
    stepIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic stepAndCheck(input logic dir, input logic half, input string req);
    setMode(dir, half);
    pulse();
    expState = expNext(expState, dir, half, 1'b1);
    checkAll(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R1 reset state");

    // R3 half forward including 7->0 wrap
    for (int i = 0; i < 9; i++) stepAndCheck(1'b1, 1'b1, "R3 half fwd");
    // R4 half backward from 1: 0 -> 7 wrap
    stepAndCheck(1'b0, 1'b1, "R4 half back");
    stepAndCheck(1'b0, 1'b1, "R4 half back wrap");

    // R6 two-phase-on from odd position (stepState 0)
    setMode(1'b1, 1'b1);
    @(negedge clk); homeN = 1'b0; repeat (4) @(negedge clk);
    homeN = 1'b1; repeat (4) @(negedge clk);
    expState = 3'd0;
    checkAll("R2 home");
    for (int i = 0; i < 5; i++) begin
      stepAndCheck(1'b1, 1'b0, "R6 two-on fwd");
      check("R6 both enabled", {5'd0, enA, enB}, 7'b0000011);
    end
    for (int i = 0; i < 3; i++) stepAndCheck(1'b0, 1'b0, "R5 full back");

    // R7 wave: reach even position with one half step, then full
    stepAndCheck(1'b1, 1'b1, "R3 to even");
    for (int i = 0; i < 5; i++) begin
      stepAndCheck(1'b1, 1'b0, "R7 wave fwd");
      check("R7 one enabled", {6'd0, enA ^ enB}, 7'd1);
    end
    for (int i = 0; i < 5; i++) stepAndCheck(1'b0, 1'b0, "R7 wave back");

    // R9 no rising edge: mode/dir toggles and held step
    setMode(1'b0, 1'b1);
    setMode(1'b1, 1'b0);
    checkAll("R9 mode change only");
    @(negedge clk); stepIn = 1'b1;
    repeat (4) @(negedge clk);
    expState = expNext(expState, 1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    checkAll("R9 held high");
    stepIn = 1'b0;
    repeat (10) @(negedge clk);
    checkAll("R9 falling edge");

    // R10 latency
    setMode(1'b1, 1'b1);
    @(negedge clk); stepIn = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    checkAll("R10 no change after 2 edges");
    expState = expNext(expState, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    checkAll("R10 change at 3rd edge");
    repeat (4) @(negedge clk); stepIn = 1'b0; repeat (4) @(negedge clk);

    // R2 home overrides step
    @(negedge clk); homeN = 1'b0; repeat (3) @(negedge clk);
    pulse();
    expState = 3'd0;
    checkAll("R2 home overrides step");
    homeN = 1'b1; repeat (4) @(negedge clk);

    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 150; i++) begin
      logic d, h, hm;
      d  = 1'($urandom);
      h  = 1'($urandom);
      hm = ($urandom % 16) != 0;
      setMode(d, h);
      @(negedge clk); homeN = hm;
      repeat (3) @(negedge clk);
      pulse();
      expState = expNext(expState, d, h, hm);
      checkAll(hm ? (h ? "R3/R4 random half" : "R5 random full") : "R2 random home");
      homeN = 1'b1;
      repeat (4) @(negedge clk);
    end

    benchDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!benchDone) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule